// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

The block provides two 8-bit down-counters. Each counter has its own 6-bit prescaler, and each counter raises a one-cycle interrupt request when it reaches the end of its count. Software programs the block over a single-cycle write port and a combinational read port. Through these ports it sets each counter's start value, each prescaler's division ratio, the end-of-count behaviour and the input source of the second timer. It can also issue start, stop, resume and restart commands and read either counter's live value. Prescaler settings cannot be read back.

The first timer always counts a tick produced by dividing the block clock by four. The second timer has six input sources:
- the same divided tick;
- rising edges of an external pin;
- the divided tick gated by that pin;
- the divided tick after a retriggerable start edge on the pin;
- the divided tick after a one-shot start edge on the pin;
- the first timer's end-of-count pulse, which chains both timers into one longer count.

The pin passes through a two-flop synchronizer and an edge detector. Every count event is a one-cycle enable in the block clock domain.

Each channel is a three-state machine:
- **STOP**: the channel is halted.
- **ARMED**: the count is loaded and the channel waits for a trigger edge.
- **RUN**: the channel is counting.

The transitions are:
- A stop command moves any state to STOP.
- A resume command moves any state to RUN and keeps the current count and prescaler phase.
- A restart command reloads both and moves to RUN, or to ARMED when the channel is in a trigger mode.
- A trigger edge in ARMED reloads the channel and moves to RUN.
- In RUN, a single-pass end of count moves to STOP, or to ARMED in a trigger mode.
- In RUN, a retriggerable edge reloads the channel and stays in RUN.

Top module: `dual_timer`

Register map (write address, bits):
- 0: first timer start value [7:0].
- 1: second timer start value [7:0].
- 2: first prescaler ratio [5:0].
- 3: second prescaler ratio [5:0].
- 4: control. Bit 0 is first timer continuous, bit 1 is second timer continuous, and [6:4] is the second timer source.
- 5: command. [1:0] are for the first timer and [3:2] for the second timer.

Command codes: 00 none, 01 stop, 10 resume, 11 restart.

Source codes: 0 divided clock, 1 external clock, 2 gate, 3 retriggerable trigger, 4 one-shot trigger, 5 cascade.

Read address 0 returns the first count, read address 1 returns the second count, and any other read address returns zero.

## Requirements
- R1: A prescaler ratio of N from 1 to 63 divides its input ticks by N; a ratio of 0 divides by 64.
- R2: A start value of M from 1 to 255 gives M prescaled ticks per count; a start value of 0 gives 256.
- R3: End of count of the first timer pulses `irq_t0` high for exactly one cycle; the second timer does the same on `irq_t1`.
- R4: In continuous mode (control bit set) the counter reloads its start value at end of count, so the request period is 4 × ratio × start cycles for a divided-clock source.
- R5: In single-pass mode (control bit clear) the counter raises one request, then holds at 0 and stays stopped.
- R6: Stop freezes the count; resume continues downward from the frozen value; restart reloads the start value.
- R7: Reading address 0 or 1 returns the live count without affecting it; after reset both counts read 0 and both requests are low.
- R8: With source 0 the second timer counts the divided-by-four clock, giving the same period rule as the first timer.
- R9: With source 1 the second timer's prescaler counts synchronized rising edges of `ext_in`.
- R10: With source 2 the second timer advances only while the synchronized `ext_in` is high, and holds its count while it is low.
- R11: With source 3 a restart arms the timer; a rising edge of `ext_in` starts it, and a later rising edge during the count reloads the start value.
- R12: With source 4 a restart arms the timer and holds the start value until a rising edge of `ext_in`; edges arriving during the count are ignored.
- R13: With source 5 each end-of-count pulse of the first timer is one input tick of the second timer's prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (0 first count, 1 second count) |
| rd_data | output | 8 | Combinational read data |
| ext_in | input | 1 | Asynchronous external timer input |
| irq_t0 | output | 1 | First timer end-of-count pulse |
| irq_t1 | output | 1 | Second timer end-of-count pulse |

## Verification
The assertions assume that `ext_in` stays at each level for at least two clock cycles, so that every synchronized rising edge yields exactly one tick. They also assume that a gate-hold window contains no register write. The bench drives the pin only at falling clock edges, with levels that last three cycles or more. It performs every bus write as a single-cycle strobe and always stops a timer before it reprograms it, so no stale request reaches the period scoreboard.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_STOP    = 2'b01,
        CMD_RESUME  = 2'b10,
        CMD_RESTART = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        SRC_INT4     = 3'd0,
        SRC_EXTCLK   = 3'd1,
        SRC_GATE     = 3'd2,
        SRC_RETRIG   = 3'd3,
        SRC_ONESHOT  = 3'd4,
        SRC_CASCADE  = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } chan_st_e;

    localparam logic [2:0] ADDR_INIT0 = 3'd0;
    localparam logic [2:0] ADDR_INIT1 = 3'd1;
    localparam logic [2:0] ADDR_PRE0  = 3'd2;
    localparam logic [2:0] ADDR_PRE1  = 3'd3;
    localparam logic [2:0] ADDR_CTRL  = 3'd4;
    localparam logic [2:0] ADDR_CMD   = 3'd5;

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          en,
    input  logic          tick_in,
    input  logic [PW-1:0] ratio,
    output logic          tick_out
);
    localparam int DW = PW + 1;

    logic [DW-1:0] span;
    logic [DW-1:0] left_q;

    // ratio 0 stands for the full 2**PW division
    assign span     = (ratio == '0) ? DW'(1 << PW) : {1'b0, ratio};
    assign tick_out = en && tick_in && (left_q == DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= DW'(1);
        else if (load)
            left_q <= span;
        else if (en && tick_in)
            left_q <= (left_q == DW'(1)) ? span : left_q - DW'(1);
    end
endmodule

// File: rtl/dtmr_source.sv
module dtmr_source
    import dtmr_pkg::*;
#(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  src_e src,
    input  logic t0_eoc,
    output logic int_tick,
    output logic t1_tick,
    output logic t1_trig,
    output logic t1_tmode,
    output logic t1_retrig
);
    localparam int DIVW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

    logic [DIVW-1:0] div_q;
    logic [1:0]      sync_q;
    logic            prev_q;
    logic            rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == DIVW'(INT_DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + DIVW'(1);
    end
    assign int_tick = (div_q == DIVW'(INT_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_in};
            prev_q <= sync_q[1];
        end
    end
    assign rise = sync_q[1] && !prev_q;

    always_comb begin
        t1_tick   = int_tick;
        t1_trig   = 1'b0;
        t1_tmode  = 1'b0;
        t1_retrig = 1'b0;
        unique case (src)
            SRC_INT4:    t1_tick = int_tick;
            SRC_EXTCLK:  t1_tick = rise;
            SRC_GATE:    t1_tick = int_tick && sync_q[1];
            SRC_RETRIG: begin
                t1_trig   = rise;
                t1_tmode  = 1'b1;
                t1_retrig = 1'b1;
            end
            SRC_ONESHOT: begin
                t1_trig  = rise;
                t1_tmode = 1'b1;
            end
            SRC_CASCADE: t1_tick = t0_eoc;
            default:     t1_tick = int_tick;
        endcase
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          trig,
    input  logic          trig_mode,
    input  logic          retrig,
    input  logic          cont,
    input  cmd_e          cmd,
    input  logic [PW-1:0] pre_val,
    input  logic [CW-1:0] init_val,
    output logic [CW-1:0] cnt,
    output logic          eoc,
    output logic          running
);
    chan_st_e      st_q, st_d;
    logic          load;
    logic          pre_en;
    logic          pre_tick;
    logic          last;
    logic [CW-1:0] cnt_q;

    assign last   = (cnt_q == CW'(1));
    assign pre_en = (st_q == ST_RUN) && (cmd == CMD_NONE) && !load;

    dtmr_prescale #(.PW(PW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .en       (pre_en),
        .tick_in  (tick),
        .ratio    (pre_val),
        .tick_out (pre_tick)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (cmd)
            CMD_STOP:    st_d = ST_STOP;
            CMD_RESUME:  st_d = ST_RUN;
            CMD_RESTART: begin
                load = 1'b1;
                st_d = trig_mode ? ST_ARMED : ST_RUN;
            end
            CMD_NONE: begin
                unique case (st_q)
                    ST_STOP: st_d = ST_STOP;
                    ST_ARMED: begin
                        if (trig) begin
                            load = 1'b1;
                            st_d = ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (trig_mode && retrig && trig)
                            load = 1'b1;
                        else if (pre_tick && last && !cont)
                            st_d = trig_mode ? ST_ARMED : ST_STOP;
                    end
                    default: st_d = ST_STOP;
                endcase
            end
            default: st_d = st_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_STOP;
        else
            st_q <= st_d;
    end

    // count and request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eoc   <= 1'b0;
        end else begin
            eoc <= pre_tick && last;
            if (load)
                cnt_q <= init_val;
            else if (pre_tick)
                cnt_q <= last ? (cont ? init_val : '0) : cnt_q - CW'(1);
        end
    end

    assign cnt     = cnt_q;
    assign running = (st_q == ST_RUN);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int CW      = 8,
    parameter int PW      = 6,
    parameter int INT_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          ext_in,
    output logic          irq_t0,
    output logic          irq_t1
);
    localparam int NCH = 2;

    logic [CW-1:0] init_q [NCH];
    logic [PW-1:0] pre_q  [NCH];
    logic [NCH-1:0] cont_q;
    src_e          src_q;

    logic          cmd_wr;
    cmd_e          ch_cmd    [NCH];
    logic [CW-1:0] ch_cnt    [NCH];
    logic [NCH-1:0] ch_tick, ch_trig, ch_tmode, ch_retrig, ch_eoc, ch_run;
    logic          int_tick;
    logic [CW-1:0] cnt0, cnt1;
    logic          run0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                init_q[i] <= '0;
                pre_q[i]  <= '0;
            end
            cont_q <= '0;
            src_q  <= SRC_INT4;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_INIT0: init_q[0] <= wr_data;
                ADDR_INIT1: init_q[1] <= wr_data;
                ADDR_PRE0:  pre_q[0]  <= wr_data[PW-1:0];
                ADDR_PRE1:  pre_q[1]  <= wr_data[PW-1:0];
                ADDR_CTRL: begin
                    cont_q <= wr_data[1:0];
                    src_q  <= src_e'(wr_data[6:4]);
                end
                default: ;
            endcase
        end
    end

    assign cmd_wr    = wr_en && (wr_addr == ADDR_CMD);
    assign ch_cmd[0] = cmd_wr ? cmd_e'(wr_data[1:0]) : CMD_NONE;
    assign ch_cmd[1] = cmd_wr ? cmd_e'(wr_data[3:2]) : CMD_NONE;

    dtmr_source #(.INT_DIV(INT_DIV)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .src       (src_q),
        .t0_eoc    (ch_eoc[0]),
        .int_tick  (int_tick),
        .t1_tick   (ch_tick[1]),
        .t1_trig   (ch_trig[1]),
        .t1_tmode  (ch_tmode[1]),
        .t1_retrig (ch_retrig[1])
    );

    assign ch_tick[0]   = int_tick;
    assign ch_trig[0]   = 1'b0;
    assign ch_tmode[0]  = 1'b0;
    assign ch_retrig[0] = 1'b0;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dtmr_channel #(.CW(CW), .PW(PW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ch_tick[g]),
            .trig      (ch_trig[g]),
            .trig_mode (ch_tmode[g]),
            .retrig    (ch_retrig[g]),
            .cont      (cont_q[g]),
            .cmd       (ch_cmd[g]),
            .pre_val   (pre_q[g]),
            .init_val  (init_q[g]),
            .cnt       (ch_cnt[g]),
            .eoc       (ch_eoc[g]),
            .running   (ch_run[g])
        );
    end

    assign cnt0   = ch_cnt[0];
    assign cnt1   = ch_cnt[1];
    assign run0   = ch_run[0];
    assign irq_t0 = ch_eoc[0];
    assign irq_t1 = ch_eoc[1];

    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_data = cnt0;
            3'd1:    rd_data = cnt1;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dtmr_checks.sv
module dtmr_checks #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic          ext_in,
    input logic [2:0]    src,
    input logic          irq0,
    input logic          irq1,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1,
    input logic [CW-1:0] init0,
    input logic          run0
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == 3'd5);

    p_irq0_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |=> !irq0);

    p_irq1_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |=> !irq1);

    p_irq0_from_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> ($past(cnt0) == CW'(1)));

    p_irq1_from_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> ($past(cnt1) == CW'(1)));

    p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !cmd_wr) |=> $stable(cnt0));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && !cmd_wr) |=> (cnt0 == $past(cnt0)) ||
                              (cnt0 == CW'($past(cnt0) - 1'b1)) ||
                              (cnt0 == init0) || (cnt0 == '0));

    p_gate_low_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == 3'd2) && !ext_in && !$past(ext_in) && !$past(ext_in, 2) && !wr_en)
        |=> $stable(cnt1));
endmodule

bind dual_timer dtmr_checks #(.CW(CW)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ext_in  (ext_in),
    .src     (src_q),
    .irq0    (irq_t0),
    .irq1    (irq_t1),
    .cnt0    (cnt0),
    .cnt1    (cnt1),
    .init0   (init_q[0]),
    .run0    (run0)
);

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_in = 1'b0;
    logic       irq_t0, irq_t1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int    q0[$], q1[$];
    string t0q[$], t1q[$];
    int    last0 = -1, last1 = -1;
    int    n_irq0 = 0, n_irq1 = 0;
    logic  prev0 = 1'b0, prev1 = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_in(ext_in), .irq_t0(irq_t0), .irq_t1(irq_t1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: queue expected request intervals
    task automatic expect_period(input int ch, input int per, input int n, input string tag);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            if (ch == 0) begin q0.push_back(per); t0q.push_back(tag); end
            else         begin q1.push_back(per); t1q.push_back(tag); end
        end
        if (ch == 0) last0 = -1; else last1 = -1;
    endtask

    task automatic drain(input int ch, input int limit, input string tag);
        int k;
        k = 0;
        while (((ch == 0) ? q0.size() : q1.size()) != 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        check(((ch == 0) ? q0.size() : q1.size()) == 0, tag,
              (ch == 0) ? q0.size() : q1.size(), 0);
        if (ch == 0) begin q0.delete(); t0q.delete(); end
        else         begin q1.delete(); t1q.delete(); end
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_in = 1'b1;
        idle(4);
        ext_in = 1'b0;
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (irq_t0) begin
            check(!prev0, "R3 irq_t0 width", 2, 1);
            if (last0 >= 0 && q0.size() > 0) begin
                int e; string t;
                e = q0.pop_front(); t = t0q.pop_front();
                check((cyc - last0) == e, t, cyc - last0, e);
            end
            last0 = cyc;
            n_irq0++;
        end
        if (irq_t1) begin
            check(!prev1, "R3 irq_t1 width", 2, 1);
            if (last1 >= 0 && q1.size() > 0) begin
                int e; string t;
                e = q1.pop_front(); t = t1q.pop_front();
                check((cyc - last1) == e, t, cyc - last1, e);
            end
            last1 = cyc;
            n_irq1++;
        end
        prev0 = irq_t0;
        prev1 = irq_t1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a, b, c;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R7 reset state
        rd(3'd0, a); check(a == 0, "R7 reset count0", a, 0);
        rd(3'd1, a); check(a == 0, "R7 reset count1", a, 0);
        check(!irq_t0 && !irq_t1, "R7 reset irq", int'(irq_t0) + int'(irq_t1), 0);

        // R4 continuous period 4*3*5, with reads during the run (R7)
        wr(3'd0, 8'd5); wr(3'd2, 8'd3); wr(3'd4, 8'h01);
        expect_period(0, 60, 3, "R4 continuous period");
        wr(3'd5, 8'h03);
        rd(3'd0, a); rd(3'd0, b); rd(3'd5, c);
        check(c == 0, "R7 unmapped read", c, 0);
        drain(0, 400, "R4 drain");
        wr(3'd5, 8'h01);

        // R2 start value 0 means 256
        wr(3'd0, 8'd0); wr(3'd2, 8'd1);
        expect_period(0, 1024, 2, "R2 start zero period");
        wr(3'd5, 8'h03);
        drain(0, 3600, "R2 drain");
        wr(3'd5, 8'h01);

        // R1 ratio 0 means 64
        wr(3'd0, 8'd1); wr(3'd2, 8'd0);
        expect_period(0, 256, 2, "R1 ratio zero period");
        wr(3'd5, 8'h03);
        drain(0, 1000, "R1 drain");
        wr(3'd5, 8'h01);

        // R5 single pass
        wr(3'd0, 8'd3); wr(3'd2, 8'd2); wr(3'd4, 8'h00);
        idle(2);
        n_irq0 = 0;
        wr(3'd5, 8'h03);
        idle(80);
        check(n_irq0 == 1, "R5 single request count", n_irq0, 1);
        rd(3'd0, a); check(a == 0, "R5 holds zero", a, 0);
        idle(60);
        rd(3'd0, a); check(a == 0 && n_irq0 == 1, "R5 stays stopped", a, 0);

        // R6 stop, resume, restart
        wr(3'd0, 8'd200); wr(3'd2, 8'd4); wr(3'd4, 8'h01);
        wr(3'd5, 8'h03);
        idle(100);
        wr(3'd5, 8'h01);
        rd(3'd0, a);
        check(a < 200, "R6 counted before stop", a, 199);
        idle(50);
        rd(3'd0, b); check(b == a, "R6 stop freezes", b, a);
        wr(3'd5, 8'h02);
        idle(40);
        rd(3'd0, c); check(c < a && c > a - 5, "R6 resume continues", c, a - 2);
        wr(3'd5, 8'h03);
        idle(2);
        rd(3'd0, a); check(a == 200, "R6 restart reloads", a, 200);
        wr(3'd5, 8'h01);

        // R8 second timer on divided clock, period 4*5*4
        wr(3'd1, 8'd4); wr(3'd3, 8'd5); wr(3'd4, 8'h02);
        expect_period(1, 80, 2, "R8 divided clock period");
        wr(3'd5, 8'h0C);
        drain(1, 400, "R8 drain");
        wr(3'd5, 8'h04);

        // R9 external clock: rise every 6 cycles, period 6*2*3
        wr(3'd1, 8'd3); wr(3'd3, 8'd2); wr(3'd4, 8'h12);
        expect_period(1, 36, 2, "R9 external clock period");
        wr(3'd5, 8'h0C);
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk); ext_in = 1'b1; idle(2);
                    @(negedge clk); ext_in = 1'b0; idle(2);
                end
            end
            drain(1, 230, "R9 drain");
        join
        wr(3'd5, 8'h04);
        ext_in = 1'b0;

        // R10 gate
        wr(3'd1, 8'd50); wr(3'd3, 8'd1); wr(3'd4, 8'h22);
        wr(3'd5, 8'h0C);
        idle(100);
        rd(3'd1, a); check(a == 50, "R10 gate low holds", a, 50);
        ext_in = 1'b1;
        idle(40);
        rd(3'd1, a); check(a < 50, "R10 gate high counts", a, 49);
        ext_in = 1'b0;
        idle(6);
        rd(3'd1, a);
        idle(60);
        rd(3'd1, b); check(b == a, "R10 gate closed holds", b, a);
        wr(3'd5, 8'h04);

        // R11 retriggerable
        wr(3'd1, 8'd10); wr(3'd3, 8'd4); wr(3'd4, 8'h30);
        wr(3'd5, 8'h0C);
        idle(60);
        rd(3'd1, a); check(a == 10, "R11 armed waits", a, 10);
        pulse_ext();
        idle(100);
        rd(3'd1, a); check(a < 10, "R11 trigger starts count", a, 9);
        pulse_ext();
        idle(6);
        rd(3'd1, a); check(a == 10, "R11 retrigger reloads", a, 10);
        wr(3'd5, 8'h04);

        // R12 one-shot trigger
        wr(3'd4, 8'h40);
        wr(3'd5, 8'h0C);
        idle(60);
        rd(3'd1, a); check(a == 10, "R12 armed holds start", a, 10);
        pulse_ext();
        idle(100);
        rd(3'd1, a); check(a < 10, "R12 trigger starts count", a, 9);
        pulse_ext();
        idle(6);
        rd(3'd1, b); check(b <= a, "R12 edge ignored while running", b, a);
        wr(3'd5, 8'h04);

        // R13 cascade: first period 8, second 8*2*3
        wr(3'd0, 8'd2); wr(3'd2, 8'd1); wr(3'd1, 8'd3); wr(3'd3, 8'd2);
        wr(3'd4, 8'h53);
        expect_period(1, 48, 2, "R13 cascade period");
        wr(3'd5, 8'h0F);
        drain(1, 400, "R13 drain");
        wr(3'd5, 8'h05);

        idle(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule